// File: doc/BRIEF.md
# Local Interrupt Timer Unit

A per-core programmable timer that raises an interrupt request after a programmed interval. Software programs it through a small write port and reads it back through a combinational read port. There are five registers: the initial count, the current count (read-only), the divide setting, the mode/vector word and a 64-bit deadline.

In the two count modes, a down-counter is clocked by ticks from a free-running prescaler. The current count keeps moving whatever mode is programmed. The mode word is looked at only at the moment the count reaches zero, and it then decides whether to reload and whether to request an interrupt. Switching between one-shot and periodic therefore never stops a running count. Entering or leaving deadline mode wipes both the count and the deadline.

In deadline mode the unit compares a nonzero deadline against a free-running timestamp input and fires once. Each expiry that is not masked produces a one-cycle request carrying the 8-bit vector. Delivery and prioritisation of that request are left to the surrounding interrupt logic.

Top module: `ltu_timer_unit`

## Requirements
- R1: A write to address 0 (initial count) loads both the initial-count and current-count registers with wr_data[31:0] at that clock edge, unless the mode is deadline, in which case the write is ignored.
- R2: The current count decrements by one on each prescaler tick while it is nonzero, in every mode. The prescaler is a 7-bit counter that starts at 0 in the first cycle after the internal reset releases (two clock edges after rst_n rises) and increments every cycle. A tick occurs when its low k bits are all ones, where k is the divide code (divide by 2^k).
- R3: A write to address 3 (mode word: vector in bits 7:0, mask in bit 8, mode in bits 10:9 with 0 one-shot, 1 periodic, 2 deadline, 3 acting as one-shot) has no immediate effect on the count. The mode and mask in force at the cycle the count goes from 1 to 0 decide what happens.
- R4: On expiry in periodic mode, the count reloads from the initial count. In the other modes it stays at zero.
- R5: Writing zero to the initial count disarms the timer: the current count becomes zero and no count expiry occurs until a nonzero value is written.
- R6: A mode change between one-shot and periodic leaves the running count undisturbed.
- R7: A mode write that enters or leaves deadline mode clears the initial count, the current count and the deadline to zero.
- R8: A write to address 2 (divide code in bits 2:0) changes the tick rate from the next cycle on, without reloading the count in progress.
- R9: In deadline mode, when the deadline (address 4) is nonzero and timestamp >= deadline, the unit fires once and clears the deadline. A deadline of zero never fires. A deadline write in a cycle takes precedence over the comparison in that cycle.
- R10: With the mask bit set, an expiry raises no request, but reloading and clearing still follow the mode.
- R11: Each unmasked expiry drives irq_valid high for the single cycle after the expiry cycle, with irq_vector equal to the vector in force at expiry. irq_vector is zero when irq_valid is low.
- R12: Writes to address 1 (current count) are ignored.
- R13: After reset, every register reads zero and irq_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 init, 1 current, 2 divide, 3 mode, 4 deadline |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address, same map as the write side |
| rd_data | output | 64 | Combinational read data, zero-extended |
| timestamp | input | 64 | Free-running timestamp for deadline mode |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The deadline property assumes that the timestamp never decreases and that it cannot wrap between a comparison and the cycle after it. The stimulus advances the timestamp by exactly one per clock from zero, and it draws deadlines a short distance above the current timestamp. The properties also take the write port to carry one register access per cycle, with the address held for the whole cycle. The bench drives every input only at the falling edge, which keeps that condition. Random mode words rarely select deadline mode, so transitions into and out of it occur without starving the count modes.

// File: rtl/ltu_pkg.sv
package ltu_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } ltu_mode_e;

  localparam int LTU_ADDR_W   = 3;
  localparam int LTU_VEC_W    = 8;
  localparam int LTU_MASK_BIT = 8;
  localparam int LTU_MODE_LSB = 9;
  localparam int LTU_LVT_W    = 11;

  localparam logic [LTU_ADDR_W-1:0] ADDR_INIT = 3'd0;
  localparam logic [LTU_ADDR_W-1:0] ADDR_CUR  = 3'd1;
  localparam logic [LTU_ADDR_W-1:0] ADDR_DIV  = 3'd2;
  localparam logic [LTU_ADDR_W-1:0] ADDR_LVT  = 3'd3;
  localparam logic [LTU_ADDR_W-1:0] ADDR_DL   = 3'd4;

  function automatic logic mode_is_dl(input logic [1:0] m);
    return (m == 2'(MODE_DEADLINE));
  endfunction

endpackage

// File: rtl/ltu_prescaler.sv
module ltu_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] sel_mask;

  // Bit g takes part in the terminal compare when g < div_code
  for (genvar g = 0; g < PRE_W; g++) begin : g_sel
    assign sel_mask[g] = (int'(div_code) > g);
  end

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    tick  = &(cnt_q | ~sel_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ltu_countdown.sv
module ltu_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             periodic,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  logic [CNT_W-1:0] init_d;
  logic [CNT_W-1:0] cur_d;
  logic             running;
  logic             upd_en;

  always_comb begin
    running = tick && (cur_q != '0);
    expire  = tick && (cur_q == CNT_W'(1));
    init_d  = init_q;
    cur_d   = cur_q;
    if (running) begin
      if (expire) begin
        cur_d = periodic ? init_q : '0;
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
    if (load_en) begin
      init_d = load_val;
      cur_d  = load_val;
    end
    if (clear) begin
      init_d = '0;
      cur_d  = '0;
    end
    upd_en = running || load_en || clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (upd_en) begin
      init_q <= init_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/ltu_deadline.sv
module ltu_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed_mode,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_val,
  input  logic            clear,
  input  logic [TS_W-1:0] timestamp,
  output logic [TS_W-1:0] dl_q,
  output logic            expire
);
  logic [TS_W-1:0] dl_d;
  logic            upd_en;

  always_comb begin
    expire = armed_mode && (dl_q != '0) && (timestamp >= dl_q) && !wr_en;
    dl_d   = dl_q;
    if (expire) begin
      dl_d = '0;
    end
    if (wr_en) begin
      dl_d = wr_val;
    end
    if (clear) begin
      dl_d = '0;
    end
    upd_en = expire || wr_en || clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q <= '0;
    end else if (upd_en) begin
      dl_q <= dl_d;
    end
  end
endmodule

// File: rtl/ltu_timer_unit.sv
module ltu_timer_unit
  import ltu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int DIV_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LTU_ADDR_W-1:0] wr_addr,
  input  logic [TS_W-1:0]       wr_data,
  input  logic [LTU_ADDR_W-1:0] rd_addr,
  output logic [TS_W-1:0]       rd_data,
  input  logic [TS_W-1:0]       timestamp,
  output logic                  irq_valid,
  output logic [LTU_VEC_W-1:0]  irq_vector
);
  localparam int PAD_CNT = TS_W - CNT_W;
  localparam int PAD_DIV = TS_W - DIV_W;
  localparam int PAD_LVT = TS_W - LTU_LVT_W;

  // reset synchroniser
  logic rst_s1_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  // register state
  logic [DIV_W-1:0]     div_q, div_d;
  logic                 div_en;
  logic [LTU_LVT_W-1:0] lvt_q, lvt_d;
  logic                 lvt_en;
  logic                 irq_q, irq_d;
  logic [LTU_VEC_W-1:0] vec_q, vec_d;

  ltu_mode_e            mode_q;
  logic                 mask_q;
  logic [LTU_VEC_W-1:0] vector_q;
  logic                 in_dl;
  logic                 periodic;

  logic                 wr_init, wr_div, wr_lvt, wr_dl;
  logic                 dl_switch;
  logic                 load_ok;

  logic                 tick;
  logic [CNT_W-1:0]     init_q, cur_q;
  logic                 cnt_expire;
  logic [TS_W-1:0]      dl_q;
  logic                 dl_expire;

  always_comb begin
    mode_q   = ltu_mode_e'(lvt_q[LTU_MODE_LSB +: 2]);
    mask_q   = lvt_q[LTU_MASK_BIT];
    vector_q = lvt_q[LTU_VEC_W-1:0];
    in_dl    = mode_is_dl(lvt_q[LTU_MODE_LSB +: 2]);
    periodic = (mode_q == MODE_PERIODIC);

    wr_init  = wr_en && (wr_addr == ADDR_INIT);
    wr_div   = wr_en && (wr_addr == ADDR_DIV);
    wr_lvt   = wr_en && (wr_addr == ADDR_LVT);
    wr_dl    = wr_en && (wr_addr == ADDR_DL);

    dl_switch = wr_lvt && (mode_is_dl(wr_data[LTU_MODE_LSB +: 2]) != in_dl);
    load_ok   = wr_init && !in_dl;

    div_en = wr_div;
    div_d  = wr_data[DIV_W-1:0];
    lvt_en = wr_lvt;
    lvt_d  = wr_data[LTU_LVT_W-1:0];

    irq_d = (cnt_expire || dl_expire) && !mask_q;
    vec_d = irq_d ? vector_q : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvt_q <= '0;
    end else if (lvt_en) begin
      lvt_q <= lvt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  ltu_prescaler #(.DIV_W(DIV_W)) i_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .div_code (div_q),
    .tick     (tick)
  );

  ltu_countdown #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .periodic (periodic),
    .load_en  (load_ok),
    .load_val (wr_data[CNT_W-1:0]),
    .clear    (dl_switch),
    .init_q   (init_q),
    .cur_q    (cur_q),
    .expire   (cnt_expire)
  );

  ltu_deadline #(.TS_W(TS_W)) i_dl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .armed_mode (in_dl),
    .wr_en      (wr_dl),
    .wr_val     (wr_data),
    .clear      (dl_switch),
    .timestamp  (timestamp),
    .dl_q       (dl_q),
    .expire     (dl_expire)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_INIT: rd_data = {{PAD_CNT{1'b0}}, init_q};
      ADDR_CUR:  rd_data = {{PAD_CNT{1'b0}}, cur_q};
      ADDR_DIV:  rd_data = {{PAD_DIV{1'b0}}, div_q};
      ADDR_LVT:  rd_data = {{PAD_LVT{1'b0}}, lvt_q};
      ADDR_DL:   rd_data = dl_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/ltu_timer_checker.sv
module ltu_timer_checker
  import ltu_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [LTU_ADDR_W-1:0] wr_addr,
  input logic [TS_W-1:0]       wr_data,
  input logic [TS_W-1:0]       timestamp,
  input logic [LTU_LVT_W-1:0]  lvt_q,
  input logic [CNT_W-1:0]      init_q,
  input logic [CNT_W-1:0]      cur_q,
  input logic [TS_W-1:0]       dl_q,
  input logic                  cnt_expire,
  input logic                  irq_valid
);
  logic chk_in_dl;
  logic chk_periodic;
  logic chk_mask;
  logic chk_switch;
  logic chk_wr_init;

  assign chk_in_dl    = (lvt_q[LTU_MODE_LSB +: 2] == 2'd2);
  assign chk_periodic = (lvt_q[LTU_MODE_LSB +: 2] == 2'd1);
  assign chk_mask     = lvt_q[LTU_MASK_BIT];
  assign chk_wr_init  = wr_en && (wr_addr == ADDR_INIT);
  assign chk_switch   = wr_en && (wr_addr == ADDR_LVT) &&
                        ((wr_data[LTU_MODE_LSB +: 2] == 2'd2) != chk_in_dl);

  AST_INIT_LOADS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr_init && !chk_in_dl) |=> (cur_q == $past(wr_data[CNT_W-1:0]))); // R1

  AST_MODE_WRITE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_LVT) && !chk_switch && (cur_q > CNT_W'(1)))
      |=> ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - 1'b1))); // R3

  AST_ONESHOT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q == '0) && !chk_periodic && !chk_wr_init) |=> (cur_q == '0)); // R4

  AST_ZERO_INIT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |-> ((cur_q == '0) && !cnt_expire)); // R5

  AST_DL_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_switch |=> ((init_q == '0) && (cur_q == '0) && (dl_q == '0))); // R7

  AST_DL_FIRE_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && $past(chk_in_dl)) |-> ($past(timestamp >= dl_q) && (dl_q == '0))); // R9

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(chk_mask)); // R10

  AST_CUR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_CUR) && (cur_q > CNT_W'(1)))
      |=> ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - 1'b1))); // R12
endmodule

bind ltu_timer_unit ltu_timer_checker #(.CNT_W(CNT_W), .TS_W(TS_W)) i_ltu_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .timestamp  (timestamp),
  .lvt_q      (lvt_q),
  .init_q     (init_q),
  .cur_q      (cur_q),
  .dl_q       (dl_q),
  .cnt_expire (cnt_expire),
  .irq_valid  (irq_valid)
);

// File: tb/test_ltu_timer_unit.sv
module test_ltu_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic [2:0]  rd_addr;
  logic [63:0] rd_data;
  logic [63:0] ts;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_errors = 0;
  int irq_seen = 0;
  bit done = 0;

  ltu_timer_unit i_ltu_timer_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .timestamp  (ts),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // reference model, built from the requirements
  bit          m_s1, m_s2;
  logic [6:0]  m_pre;
  logic [2:0]  m_div;
  logic [10:0] m_lvt;
  logic [31:0] m_init, m_cur;
  logic [63:0] m_dl;
  bit          m_irq;
  logic [7:0]  m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pre = '0; m_div = '0; m_lvt = '0;
      m_init = '0; m_cur = '0; m_dl = '0; m_irq = 0; m_vec = '0;
    end else if (!m_s2) begin
      m_s2 = m_s1;
      m_s1 = 1;
    end else begin
      bit          tk, cexp, dexp, isdl, dl_wr;
      logic [1:0]  md;
      logic [31:0] n_init, n_cur;
      logic [63:0] n_dl;
      logic [2:0]  n_div;
      logic [10:0] n_lvt;
      md    = m_lvt[10:9];
      isdl  = (md == 2'd2);
      tk    = ((m_pre & 7'((1 << m_div) - 1)) == 7'((1 << m_div) - 1));
      cexp  = tk && (m_cur == 32'd1);
      dl_wr = wr_en && (wr_addr == 3'd4);
      dexp  = isdl && (m_dl != 0) && (ts >= m_dl) && !dl_wr;
      n_cur = m_cur;
      if (tk && m_cur != 0) n_cur = cexp ? ((md == 2'd1) ? m_init : 32'd0) : m_cur - 1;
      n_init = m_init;
      n_dl   = dexp ? 64'd0 : m_dl;
      n_div  = m_div;
      n_lvt  = m_lvt;
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!isdl) begin n_init = wr_data[31:0]; n_cur = wr_data[31:0]; end
          3'd2: n_div = wr_data[2:0];
          3'd3: begin
            n_lvt = wr_data[10:0];
            if ((wr_data[10:9] == 2'd2) != isdl) begin n_init = 0; n_cur = 0; n_dl = 0; end
          end
          3'd4: n_dl = wr_data;
          default: ;
        endcase
      end
      m_irq  = (cexp || dexp) && !m_lvt[8];
      m_vec  = m_irq ? m_lvt[7:0] : 8'd0;
      m_cur  = n_cur; m_init = n_init; m_dl = n_dl; m_div = n_div; m_lvt = n_lvt;
      m_pre  = m_pre + 7'd1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {32'd0, m_init};
      3'd1: return {32'd0, m_cur};
      3'd2: return {61'd0, m_div};
      3'd3: return {53'd0, m_lvt};
      3'd4: return m_dl;
      default: return 64'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1 init readback";
      3'd1: return "R2 current count";
      3'd2: return "R8 divide readback";
      3'd3: return "R3 mode readback";
      default: return "R9 deadline readback";
    endcase
  endfunction

  task automatic compare();
    check(irq_valid == m_irq, "R11 irq_valid", {63'd0, irq_valid}, {63'd0, m_irq});
    check(irq_vector == m_vec, "R11 irq_vector", {56'd0, irq_vector}, {56'd0, m_vec});
    check(rd_data == exp_rd(rd_addr), rd_tag(rd_addr), rd_data, exp_rd(rd_addr));
    if (irq_valid) irq_seen++;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ts = ts + 64'd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] c0;
    int k;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; ts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R13 reset state
    for (int a = 0; a < 5; a++) begin
      rd_addr = 3'(a);
      #1;
      check(rd_data == 64'd0, "R13 reset register", rd_data, 64'd0);
    end
    check(irq_valid == 1'b0, "R13 reset irq", {63'd0, irq_valid}, 64'd0);

    // R1 load, R4 one-shot expiry
    rd_addr = 3'd1;
    wr(3'd3, 64'h0A5);
    wr(3'd0, 64'd10);
    check(rd_data == 64'd10, "R1 current after load", rd_data, 64'd10);
    irq_seen = 0;
    repeat (15) step();
    check(irq_seen == 1, "R4 one-shot fires once", 64'(irq_seen), 64'd1);
    check(rd_data == 64'd0, "R4 one-shot stays at zero", rd_data, 64'd0);

    // R12 current-count write ignored
    wr(3'd0, 64'd50);
    wr(3'd1, 64'd7);
    check(rd_data == 64'd49, "R12 current write ignored", rd_data, 64'd49);

    // R5 zero disarms
    wr(3'd0, 64'd0);
    irq_seen = 0;
    repeat (40) step();
    check(irq_seen == 0, "R5 disarmed no irq", 64'(irq_seen), 64'd0);
    check(rd_data == 64'd0, "R5 disarmed count", rd_data, 64'd0);

    // R10 masked periodic keeps reloading
    wr(3'd3, 64'h333);
    wr(3'd0, 64'd4);
    irq_seen = 0;
    repeat (20) step();
    check(irq_seen == 0, "R10 masked no irq", 64'(irq_seen), 64'd0);
    check(rd_data != 64'd0, "R10 masked still reloads", rd_data, 64'd1);

    // R6 periodic to one-shot mid count
    wr(3'd3, 64'h25A);
    wr(3'd0, 64'd100);
    repeat (10) step();
    wr(3'd3, 64'h05A);
    check(rd_data == 64'd89, "R6 count undisturbed", rd_data, 64'd89);

    // R8 divide change on the running count
    wr(3'd2, 64'd3);
    c0 = rd_data;
    repeat (16) step();
    check(c0 - rd_data == 64'd2, "R8 slower rate", c0 - rd_data, 64'd2);

    // R7 entering deadline clears counts
    rd_addr = 3'd0;
    wr(3'd3, 64'h47C);
    check(rd_data == 64'd0, "R7 init cleared", rd_data, 64'd0);
    wr(3'd0, 64'd9);
    check(rd_data == 64'd0, "R1 init write ignored in deadline", rd_data, 64'd0);

    // R9 deadline fires once then clears
    rd_addr = 3'd4;
    irq_seen = 0;
    wr(3'd4, ts + 64'd6);
    repeat (15) step();
    check(irq_seen == 1, "R9 deadline fires once", 64'(irq_seen), 64'd1);
    check(rd_data == 64'd0, "R9 deadline cleared", rd_data, 64'd0);
    irq_seen = 0;
    wr(3'd4, 64'd0);
    repeat (10) step();
    check(irq_seen == 0, "R9 zero deadline silent", 64'(irq_seen), 64'd0);
    wr(3'd4, ts + 64'd500);
    wr(3'd3, 64'h011);
    check(rd_data == 64'd0, "R7 leaving deadline clears", rd_data, 64'd0);

    // constrained random phase, R2 R3 R4 R6 R8 R11 checked by the model
    for (int i = 0; i < 4000; i++) begin
      rd_addr = 3'($urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) begin
        k = $urandom_range(0, 9);
        if (k < 3)       wr(3'd0, ($urandom_range(0, 7) == 0) ? 64'd0 : 64'($urandom_range(1, 40)));
        else if (k < 4)  wr(3'd1, 64'($urandom));
        else if (k < 6)  wr(3'd2, 64'($urandom_range(0, 7) < 6 ? $urandom_range(0, 2) : $urandom_range(3, 7)));
        else if (k < 9) begin
          logic [1:0] md;
          md = ($urandom_range(0, 15) == 0) ? 2'd2 : (($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 1)));
          wr(3'd3, {53'd0, md, ($urandom_range(0, 3) == 0), 8'($urandom)});
        end
        else             wr(3'd4, ($urandom_range(0, 5) == 0) ? 64'd0 : ts + 64'($urandom_range(0, 60)));
      end else begin
        step();
      end
    end

    finish_run();
  end
endmodule